// File: doc/BRIEF.md
# Dual Byte Transceiver with Parity Generation and Checking

This block holds two independent byte-wide bidirectional transceiver sections. Each section joins an A-side byte bus to a B-side byte bus and carries one parity line and one active-low error flag. A direction input sets which way the byte travels. A high-impedance input releases both data buses of the section at once. A sense input picks odd or even parity for that section.

When a section sends A to B, it generates the parity bit from the A byte and drives it on the parity line. When it receives B into A, the parity line turns into an input. The block counts that incoming bit together with the eight B bits and pulls the error flag low when the total breaks the chosen sense.

Every pin that can be bidirectional or released appears as three things: an input value, an output value and an output enable. The block therefore needs no tri-state nets inside the chip. The logic is purely combinational. Any output value responds to its inputs in the same evaluation, with no clock and no reset.

Top module: `ptx_dual_transceiver`

## Requirements
- R1: The two sections are independent. Changing any input of section 0 leaves every output and enable of section 1 unchanged, and the other way round.
- R2: With direction high (transmit) and the release input low, the section drives B with the A byte unchanged (not inverted), sets its B enable to 1 and its A enable to 0.
- R3: With direction low (receive) and the release input low, the section drives A with the B byte unchanged (not inverted), sets its A enable to 1 and its B enable to 0.
- R4: With the release input high, the section's A, B, parity and error enables are all 0, whatever the direction.
- R5: In transmit, the parity enable is 1 (unless released). The parity output makes the count of ones over the eight A bits plus the parity bit odd when the sense input is 1, and even when it is 0. Example: even sense with five A bits high gives parity 1.
- R6: In receive, the parity enable is 0. The error output is 1 when the count of ones over the eight B bits plus the incoming parity bit has the selected sense (odd for sense 1, even for sense 0), and 0 otherwise. Example: odd sense, incoming parity 1 and three B bits high gives error 0.
- R7: In transmit, the error output is 1. The error enable is 1 in both directions unless the section is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_dir_i | input | NS | Per section: 1 sends A to B, 0 sends B to A |
| hiz_i | input | NS | Per section: 1 releases every driven pin of the section |
| odd_sel_i | input | NS | Per section: 1 selects odd parity, 0 selects even |
| a_in_i | input | NS*W | A-side bytes as seen on the bus, section s in bits s*W+:W |
| a_out_o | output | NS*W | Value offered to the A side |
| a_oe_o | output | NS | Drive enable for each section's A byte |
| b_in_i | input | NS*W | B-side bytes as seen on the bus |
| b_out_o | output | NS*W | Value offered to the B side |
| b_oe_o | output | NS | Drive enable for each section's B byte |
| par_in_i | input | NS | Parity line as seen from outside |
| par_out_o | output | NS | Generated parity value |
| par_oe_o | output | NS | Drive enable for the parity line |
| err_n_o | output | NS | Active-low parity error flag |
| err_oe_o | output | NS | Drive enable for the error flag |

## Verification
The block holds no state, so a wrong internal term shows at the ports in the same evaluation as the input that exposes it. The faults to expect are a wrong parity value or an enable left on. A broken reduction term flips the parity output, or the error flag, for exactly the byte values that toggle that term. The full sweep of every byte under every control combination therefore catches it on the first affected vector. A direction or release fault shows as two enables on at once, or as an enable left on while released. Both are visible on the next sampled vector.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } ptx_dir_e;

  typedef struct packed {
    ptx_dir_e dir;
    logic     hiz;
    logic     odd;
  } ptx_ctrl_t;
endpackage

// File: rtl/ptx_xor_chain.sv
module ptx_xor_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  output logic             odd_o
);
  logic [WIDTH-1:0] acc;

  assign acc[0] = data_i[0];
  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    assign acc[i] = acc[i-1] ^ data_i[i];
  end

  assign odd_o = acc[WIDTH-1];
endmodule

// File: rtl/ptx_dir_ctl.sv
module ptx_dir_ctl
  import ptx_pkg::*;
(
  input  ptx_ctrl_t ctrl_i,
  output logic      a_oe_o,
  output logic      b_oe_o,
  output logic      par_oe_o,
  output logic      err_oe_o
);
  logic live;
  logic sending;

  assign live     = !ctrl_i.hiz;
  assign sending  = (ctrl_i.dir == DIR_TX);
  assign a_oe_o   = live && !sending;
  assign b_oe_o   = live && sending;
  assign par_oe_o = live && sending;
  assign err_oe_o = live;

  always_comb begin
    AST_NO_CONTENTION: assert (!(a_oe_o && b_oe_o)); // R2
    if (ctrl_i.hiz)
      AST_RELEASED_QUIET: assert (!a_oe_o && !b_oe_o && !par_oe_o && !err_oe_o); // R4
  end
endmodule

// File: rtl/ptx_section.sv
module ptx_section
  import ptx_pkg::*;
#(
  parameter int W = 8
) (
  input  ptx_ctrl_t    ctrl_i,
  input  logic [W-1:0] a_in_i,
  output logic [W-1:0] a_out_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_in_i,
  output logic [W-1:0] b_out_o,
  output logic         b_oe_o,
  input  logic         par_in_i,
  output logic         par_out_o,
  output logic         par_oe_o,
  output logic         err_n_o,
  output logic         err_oe_o
);
  localparam int CHK_W = W + 1;

  logic a_odd;
  logic rx_odd;

  ptx_xor_chain #(.WIDTH(W)) u_gen (
    .data_i (a_in_i),
    .odd_o  (a_odd)
  );

  ptx_xor_chain #(.WIDTH(CHK_W)) u_chk (
    .data_i ({par_in_i, b_in_i}),
    .odd_o  (rx_odd)
  );

  ptx_dir_ctl u_ctl (
    .ctrl_i   (ctrl_i),
    .a_oe_o   (a_oe_o),
    .b_oe_o   (b_oe_o),
    .par_oe_o (par_oe_o),
    .err_oe_o (err_oe_o)
  );

  assign b_out_o   = a_in_i;
  assign a_out_o   = b_in_i;
  assign par_out_o = a_odd ^ ctrl_i.odd;
  assign err_n_o   = (ctrl_i.dir == DIR_TX) ? 1'b1 : !(rx_odd ^ ctrl_i.odd);

  always_comb begin
    if (ctrl_i.dir == DIR_TX) begin
      AST_TX_SENSE: assert ((^{a_in_i, par_out_o}) == ctrl_i.odd); // R5
      AST_TX_NO_ERR: assert (err_n_o); // R7
    end else begin
      AST_RX_PAR_IN: assert (!par_oe_o); // R6
      AST_RX_FLAG: assert (err_n_o == ((^{b_in_i, par_in_i}) == ctrl_i.odd)); // R6
    end
  end
endmodule

// File: rtl/ptx_dual_transceiver.sv
module ptx_dual_transceiver
  import ptx_pkg::*;
#(
  parameter int NS = 2,
  parameter int W  = 8
) (
  input  logic [NS-1:0]   tx_dir_i,
  input  logic [NS-1:0]   hiz_i,
  input  logic [NS-1:0]   odd_sel_i,
  input  logic [NS*W-1:0] a_in_i,
  output logic [NS*W-1:0] a_out_o,
  output logic [NS-1:0]   a_oe_o,
  input  logic [NS*W-1:0] b_in_i,
  output logic [NS*W-1:0] b_out_o,
  output logic [NS-1:0]   b_oe_o,
  input  logic [NS-1:0]   par_in_i,
  output logic [NS-1:0]   par_out_o,
  output logic [NS-1:0]   par_oe_o,
  output logic [NS-1:0]   err_n_o,
  output logic [NS-1:0]   err_oe_o
);
  for (genvar s = 0; s < NS; s++) begin : g_sec
    ptx_ctrl_t ctrl;

    assign ctrl.dir = ptx_dir_e'(tx_dir_i[s]);
    assign ctrl.hiz = hiz_i[s];
    assign ctrl.odd = odd_sel_i[s];

    ptx_section #(.W(W)) u_sec (
      .ctrl_i    (ctrl),
      .a_in_i    (a_in_i[s*W +: W]),
      .a_out_o   (a_out_o[s*W +: W]),
      .a_oe_o    (a_oe_o[s]),
      .b_in_i    (b_in_i[s*W +: W]),
      .b_out_o   (b_out_o[s*W +: W]),
      .b_oe_o    (b_oe_o[s]),
      .par_in_i  (par_in_i[s]),
      .par_out_o (par_out_o[s]),
      .par_oe_o  (par_oe_o[s]),
      .err_n_o   (err_n_o[s]),
      .err_oe_o  (err_oe_o[s])
    );
  end
endmodule

// File: tb/test_ptx_dual_transceiver.sv
module test_ptx_dual_transceiver;
  localparam int NS = 2;
  localparam int W  = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [NS-1:0]   dir, hiz, odd, pin;
  logic [NS*W-1:0] ain, bin;
  logic [NS*W-1:0] aout, bout;
  logic [NS-1:0]   aoe, boe, pout, poe, errn, eoe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  ptx_dual_transceiver #(.NS(NS), .W(W)) i_ptx_dual_transceiver (
    .tx_dir_i(dir), .hiz_i(hiz), .odd_sel_i(odd),
    .a_in_i(ain), .a_out_o(aout), .a_oe_o(aoe),
    .b_in_i(bin), .b_out_o(bout), .b_oe_o(boe),
    .par_in_i(pin), .par_out_o(pout), .par_oe_o(poe),
    .err_n_o(errn), .err_oe_o(eoe)
  );

  // Vector: dir, hiz, odd, par_in, a[8], b[8], expected parity, expected err_n
  localparam logic [21:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h1F, 8'h00, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h1F, 8'h00, 1'b0, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h01, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h07, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h07, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h80, 1'b0, 1'b1}
  };

  task automatic chk(string req, int s, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s section %0d: got %0h expected %0h", req, s, got, exp);
    end
  endtask

  function automatic int ones(logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check_sec(int s);
    logic z  = hiz[s];
    logic tx = dir[s];
    logic [W-1:0] a = ain[s*W +: W];
    logic [W-1:0] b = bin[s*W +: W];
    logic ep = ((ones(a) + 1) % 2 == int'(odd[s])) ? 1'b1 : 1'b0;
    logic ee = ((ones(b) + int'(pin[s])) % 2 == int'(odd[s])) ? 1'b1 : 1'b0;
    chk(z ? "R4 a_oe" : "R3 a_oe", s, 32'(aoe[s]), 32'(!z && !tx));
    chk(z ? "R4 b_oe" : "R2 b_oe", s, 32'(boe[s]), 32'(!z && tx));
    chk(z ? "R4 par_oe" : (tx ? "R5 par_oe" : "R6 par_oe"), s, 32'(poe[s]), 32'(!z && tx));
    chk(z ? "R4 err_oe" : "R7 err_oe", s, 32'(eoe[s]), 32'(!z));
    if (tx) begin
      chk("R2 b_out", s, 32'(bout[s*W +: W]), 32'(a));
      chk("R5 parity", s, 32'(pout[s]), 32'(ep));
      chk("R7 err_n", s, 32'(errn[s]), 32'h1);
    end else begin
      chk("R3 a_out", s, 32'(aout[s*W +: W]), 32'(b));
      chk("R6 err_n", s, 32'(errn[s]), 32'(ee));
    end
  endtask

  initial begin
    logic [NS*W+4*NS-1:0] snap;
    dir = '0; hiz = '1; odd = '0; pin = '0; ain = '0; bin = '0;
    @(negedge clk);
    // Quiescent state: everything released (R4)
    chk("R4 idle enables", 0, 32'({aoe, boe, poe, eoe}), 32'h0);

    // Table walk on section 0, section 1 held in receive
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      {dir[0], hiz[0], odd[0], pin[0], ain[7:0], bin[7:0]} = VEC[k][21:2];
      dir[1] = 1'b0; hiz[1] = 1'b0; odd[1] = 1'b1; pin[1] = 1'b1;
      ain[15:8] = 8'h3C; bin[15:8] = 8'h0F;
      @(negedge clk);
      if (dir[0]) chk("R5 table parity", 0, 32'(pout[0]), 32'(VEC[k][1]));
      chk(dir[0] ? "R7 table err_n" : "R6 table err_n", 0, 32'(errn[0]), 32'(VEC[k][0]));
      check_sec(0);
      check_sec(1);
    end

    // Full sweep: every byte, direction, release, sense and incoming parity
    for (int dv = 0; dv < 2; dv++)
      for (int zv = 0; zv < 2; zv++)
        for (int ov = 0; ov < 2; ov++)
          for (int pv = 0; pv < 2; pv++)
            for (int by = 0; by < 256; by++) begin
              @(posedge clk);
              dir = {1'(!dv), 1'(dv)};
              hiz = {1'b0, 1'(zv)};
              odd = {1'(!ov), 1'(ov)};
              pin = {1'(!pv), 1'(pv)};
              ain = {8'(by * 3 + 1), ~8'(by)};
              bin = {8'(by + 7), 8'(by)};
              @(negedge clk);
              check_sec(0);
              check_sec(1);
            end

    // R1: section 1 unaffected by section 0 changes
    @(posedge clk);
    dir = 2'b01; hiz = 2'b00; odd = 2'b10; pin = 2'b10; ain = 16'hA55A; bin = 16'h3CC3;
    @(negedge clk);
    snap = {aout[15:8], aoe[1], boe[1], bout[15:8], pout[1], poe[1], errn[1], eoe[1]};
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      dir[0] = 1'(k); hiz[0] = 1'(k >> 1); odd[0] = ~odd[0]; pin[0] = ~pin[0];
      ain[7:0] = 8'(k * 37); bin[7:0] = 8'(k * 91);
      @(negedge clk);
      chk("R1 isolation", 1,
          32'({aout[15:8], aoe[1], boe[1], bout[15:8], pout[1], poe[1], errn[1], eoe[1]} != snap),
          32'h0);
      check_sec(0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule